// File: doc/BRIEF.md
# Daisy-Chain ADC Host Sequencer

This block is the host side of a chain of identical serial converters that share one active-low chip-select and one serial clock. The host's serial output feeds the data input of the first device in the chain, and the host samples the data output of the last device. A single start pulse runs one complete schedule. The schedule is one full conversion frame, then a shortened frame that moves every device into pass-through shifting, then one full read frame per device, then a shortened frame that returns the chain to converting.

During the read frames the host sends a leading throw-away word, then the channel commands for the devices from the last device back towards the first. The command for the first device goes out in the shortened exit frame. Returned words arrive last device first and are sorted into a per-device result array. The array, with a channel tag and a format flag per slot, is published together with a one-cycle done pulse.

The serial clock comes from the system clock through a programmable divider. The result array is a snapshot qualified by `done` and has no back-pressure. It holds its value until the next schedule publishes over it, so a consumer may read it at any time after `done`. `clk_div` must be held steady while `busy` is high.

Top module: `dchain_adc_seq`

## Requirements
- R1: Out of reset `cs_n` and `sclk` are high, `mosi`, `busy` and `done` are low, and every result slot (channel, data and format flag) is zero.
- R2: A start issues exactly N_DEV+3 frames in this order: one frame of WORD_W falling `sclk` edges, one entry frame of ENTER_FALLS falling edges (default 11, legal 11..12), N_DEV frames of WORD_W falling edges, and one exit frame of EXIT_FALLS falling edges (default 12, legal 11..13). `cs_n` rises after the last falling edge of each frame.
- R3: While `cs_n` is low, each `sclk` level, and the time from the `cs_n` fall to the first `sclk` fall, lasts exactly `clk_div`+1 system clock cycles.
- R4: Every command word has the channel in bit WORD_W-1, its inverse in bit WORD_W-2, and zeros below. In read frame j (counted from 0), j=0 sends the throw-away word (channel 0, i.e. 0x4000 for 16 bits) and j>=1 sends the command for device N_DEV-j. Device 0 is the one fed by `mosi`.
- R5: The exit frame carries the command word for device 0 in its leading bits.
- R6: `mosi` is low throughout the conversion frame and the entry frame, and whenever `cs_n` is high.
- R7: The word returned in read frame j is stored in slot N_DEV-1-j. Bit WORD_W-3 of that word is the slot's channel tag and bits WORD_W-4..0 are its data. Slot d occupies `res_data[d*DATA_W +: DATA_W]` and bit d of `res_chan`.
- R8: `done` is high for one cycle after the exit frame ends. `busy` is high from the accepted start until that cycle and low after it, and the result outputs change only in the cycle `done` rises.
- R9: A start pulse while `busy` is high is ignored: no extra frames and no extra `done`.
- R10: `cmd_chan` is sampled in the cycle the start is accepted. Later changes do not alter the command words of that schedule.
- R11: While `cs_n` stays low, `mosi` changes only on a falling `sclk` edge, and `miso` is sampled on rising `sclk` edges only.
- R12: `res_ok[d]` is set when the word stored in slot d began with two zero bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch one schedule (ignored while busy) |
| clk_div | input | DIV_W | Serial clock half-period minus one, in system cycles |
| cmd_chan | input | N_DEV | Channel for the next conversion, bit d for device d |
| busy | output | 1 | Schedule in progress |
| done | output | 1 | One-cycle pulse when results are published |
| res_chan | output | N_DEV | Channel tag per device |
| res_data | output | N_DEV*DATA_W | Conversion data per device, DATA_W = WORD_W-3 |
| res_ok | output | N_DEV | Leading-zero format flag per device |
| sclk | output | 1 | Shared serial clock, idles high |
| cs_n | output | 1 | Shared active-low chip-select |
| mosi | output | 1 | Serial data to the first device |
| miso | input | 1 | Serial data from the last device |

## Verification
The schedule is run with the command mixes 10, 01, 11 and 00, so every device is asked for both channels. A mix that differs per device exposes a reversed or shifted command order, and because the returned channel tags reflect the previous schedule's commands, the same mixes also check the wiring from commands to results through a device chain. The divider is swept over 0, 1 and 3 to separate a miscounted half-period from correct timing. A disturbed run, with a second start and a flipped command input partway through, shows whether the commands were taken at the right moment and whether a start during a run is refused.

// File: rtl/dcs_pkg.sv
`timescale 1ns/1ps
package dcs_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_CONV, PH_ENTER, PH_READ, PH_EXIT} phase_t;
  typedef enum logic [2:0] {FS_IDLE, FS_LEAD, FS_LOW, FS_HIGH, FS_TAIL, FS_GAP} fstate_t;
endpackage

// File: rtl/dcs_tick.sv
`timescale 1ns/1ps
module dcs_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  // R3: the counter never passes the programmed limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));
endmodule

// File: rtl/dcs_frame.sv
`timescale 1ns/1ps
module dcs_frame import dcs_pkg::*; #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              go,
  input  logic [CNT_W-1:0]  falls,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              miso,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word,
  output logic              fdone,
  output logic              active
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  fstate_t            fst;
  logic [CNT_W-1:0]   fcnt, falls_q;
  logic [WORD_W-1:0]  sh;

  assign active = (fst != FS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fst     <= FS_IDLE;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      rx_word <= '0;
      fdone   <= 1'b0;
      fcnt    <= '0;
      falls_q <= '0;
      sh      <= '0;
    end else begin
      fdone <= 1'b0;
      case (fst)
        FS_IDLE: if (go) begin
          cs_n    <= 1'b0;
          mosi    <= tx_word[WORD_W-1];
          sh      <= tx_word;
          falls_q <= falls;
          fcnt    <= '0;
          fst     <= FS_LEAD;
        end
        FS_LEAD, FS_HIGH: if (tick) begin
          if (fst == FS_HIGH && fcnt == falls_q) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            fst  <= FS_GAP;
          end else begin
            sclk <= 1'b0;
            mosi <= sh[WORD_W-1];
            sh   <= {sh[WORD_W-2:0], 1'b0};
            fcnt <= fcnt + 1'b1;
            fst  <= FS_LOW;
          end
        end
        FS_LOW: if (tick) begin
          if (fcnt == falls_q && falls_q != FULL) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            fst  <= FS_TAIL;
          end else begin
            sclk    <= 1'b1;
            rx_word <= {rx_word[WORD_W-2:0], miso};
            fst     <= FS_HIGH;
          end
        end
        FS_TAIL: if (tick) begin
          sclk <= 1'b1;
          fst  <= FS_GAP;
        end
        FS_GAP: if (tick) begin
          fdone <= 1'b1;
          fst   <= FS_IDLE;
        end
        default: fst <= FS_IDLE;
      endcase
    end
  end

  // R2: chip-select rises only once the requested number of falling edges is out
  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (fcnt == falls_q));
  // R11: data out moves only with a falling serial clock inside a frame
  a_r11_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $stable(cs_n) && !$fell(sclk)) |-> $stable(mosi));
  // R1: an idle engine leaves the serial lines parked
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (fst == FS_IDLE) |-> (cs_n && sclk && !mosi));
endmodule

// File: rtl/dcs_cmd_order.sv
`timescale 1ns/1ps
module dcs_cmd_order import dcs_pkg::*; #(
  parameter int N_DEV  = 2,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [N_DEV-1:0]  cmd_chan,
  input  phase_t            phase,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] tx_word
);
  logic [N_DEV-1:0] bank;
  logic             sel_ch;

  function automatic logic [WORD_W-1:0] mk_cmd(input logic c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[WORD_W-1] = c;
    w[WORD_W-2] = ~c;
    return w;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= '0;
    else if (load) bank <= cmd_chan;
  end

  // read frame j (j>=1) targets device N_DEV-j
  always_comb begin
    sel_ch = 1'b0;
    for (int d = 0; d < N_DEV; d++)
      if (int'(idx) + d == N_DEV) sel_ch = bank[d];
  end

  always_comb begin
    case (phase)
      PH_READ: tx_word = (idx == '0) ? mk_cmd(1'b0) : mk_cmd(sel_ch);
      PH_EXIT: tx_word = mk_cmd(bank[0]);
      default: tx_word = '0;
    endcase
  end
endmodule

// File: rtl/dcs_result_store.sv
`timescale 1ns/1ps
module dcs_result_store #(
  parameter int N_DEV  = 2,
  parameter int WORD_W = 16,
  parameter int DATA_W = 13,
  parameter int IDX_W  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]       rx_word,
  input  logic                    publish,
  output logic [N_DEV-1:0]        res_chan,
  output logic [N_DEV*DATA_W-1:0] res_data,
  output logic [N_DEV-1:0]        res_ok
);
  logic [N_DEV-1:0]  wr_sel;
  logic [N_DEV-1:0]  stg_chan, stg_ok;
  logic [DATA_W-1:0] stg_data [N_DEV];
  logic [DATA_W-1:0] pub_data [N_DEV];

  for (genvar d = 0; d < N_DEV; d++) begin : g_slot
    // results arrive last device first
    assign wr_sel[d] = wr && (idx == IDX_W'(N_DEV-1-d));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_chan[d] <= 1'b0;
        stg_ok[d]   <= 1'b0;
        stg_data[d] <= '0;
        res_chan[d] <= 1'b0;
        res_ok[d]   <= 1'b0;
        pub_data[d] <= '0;
      end else begin
        if (wr_sel[d]) begin
          stg_chan[d] <= rx_word[WORD_W-3];
          stg_ok[d]   <= (rx_word[WORD_W-1:WORD_W-2] == 2'b00);
          stg_data[d] <= rx_word[DATA_W-1:0];
        end
        if (publish) begin
          res_chan[d] <= stg_chan[d];
          res_ok[d]   <= stg_ok[d];
          pub_data[d] <= stg_data[d];
        end
      end
    end

    assign res_data[d*DATA_W +: DATA_W] = pub_data[d];
  end

  // R7: a returned word lands in at most one slot
  a_r7_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/dchain_adc_seq.sv
`timescale 1ns/1ps
module dchain_adc_seq import dcs_pkg::*; #(
  parameter int N_DEV       = 2,
  parameter int WORD_W      = 16,
  parameter int DIV_W       = 8,
  parameter int ENTER_FALLS = 11,
  parameter int EXIT_FALLS  = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [DIV_W-1:0]               clk_div,
  input  logic [N_DEV-1:0]               cmd_chan,
  output logic                           busy,
  output logic                           done,
  output logic [N_DEV-1:0]               res_chan,
  output logic [N_DEV*(WORD_W-3)-1:0]    res_data,
  output logic [N_DEV-1:0]               res_ok,
  output logic                           sclk,
  output logic                           cs_n,
  output logic                           mosi,
  input  logic                           miso
);
  localparam int DATA_W = WORD_W - 3;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int IDX_W  = (N_DEV > 1) ? $clog2(N_DEV) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_DEV - 1);

  phase_t            phase;
  logic [IDX_W-1:0]  idx;
  logic              go, tick, active, fdone, load;
  logic [WORD_W-1:0] tx_word, rx_word;
  logic [CNT_W-1:0]  falls;

  assign load = start && (phase == PH_IDLE);

  always_comb begin
    case (phase)
      PH_ENTER: falls = CNT_W'(ENTER_FALLS);
      PH_EXIT:  falls = CNT_W'(EXIT_FALLS);
      default:  falls = CNT_W'(WORD_W);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      idx   <= '0;
      go    <= 1'b0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      if (load) begin
        phase <= PH_CONV;
        idx   <= '0;
        busy  <= 1'b1;
        go    <= 1'b1;
      end else if (fdone) begin
        case (phase)
          PH_CONV:  begin phase <= PH_ENTER; go <= 1'b1; end
          PH_ENTER: begin phase <= PH_READ; idx <= '0; go <= 1'b1; end
          PH_READ: begin
            if (idx == LAST_IDX) phase <= PH_EXIT;
            else                 idx   <= idx + 1'b1;
            go <= 1'b1;
          end
          PH_EXIT: begin
            phase <= PH_IDLE;
            busy  <= 1'b0;
            done  <= 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  dcs_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(active), .div(clk_div), .tick(tick)
  );

  dcs_cmd_order #(.N_DEV(N_DEV), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .load(load), .cmd_chan(cmd_chan),
    .phase(phase), .idx(idx), .tx_word(tx_word)
  );

  dcs_frame #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .falls(falls),
    .tx_word(tx_word), .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .rx_word(rx_word), .fdone(fdone), .active(active)
  );

  dcs_result_store #(.N_DEV(N_DEV), .WORD_W(WORD_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr(fdone && phase == PH_READ), .idx(idx),
    .rx_word(rx_word), .publish(fdone && phase == PH_EXIT),
    .res_chan(res_chan), .res_data(res_data), .res_ok(res_ok)
  );

  // R8: done lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8: busy only drops together with done
  a_r8_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R9: nothing but the exit frame ends a running schedule
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != PH_EXIT) |=> busy);
  // R4: read-frame words keep the chain shifting
  a_r4_stay_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_READ) |-> (tx_word[WORD_W-1] != tx_word[WORD_W-2]));
endmodule

// File: tb/dchain_adc_seq_tb.sv
`timescale 1ns/1ps
module dchain_adc_seq_tb;
  localparam int N     = 2;
  localparam int W     = 16;
  localparam int DW    = W - 3;
  localparam int ENTER = 11;
  localparam int EXIT  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] clk_div = 8'd1;
  logic [N-1:0] cmd_chan = '0;
  logic busy, done, sclk, cs_n, mosi, miso;
  logic [N-1:0] res_chan, res_ok;
  logic [N*DW-1:0] res_data;

  always #10 clk = ~clk;

  dchain_adc_seq #(.N_DEV(N), .WORD_W(W), .DIV_W(8), .ENTER_FALLS(ENTER), .EXIT_FALLS(EXIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clk_div(clk_div), .cmd_chan(cmd_chan),
    .busy(busy), .done(done), .res_chan(res_chan), .res_data(res_data), .res_ok(res_ok),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] dfn(input int k, input logic ch, input int n);
    return DW'((k + 1) * 801 + (ch ? 2730 : 0) + n * 87);
  endfunction

  function automatic logic [W-1:0] cw(input logic c);
    return {c, ~c, {(W-2){1'b0}}};
  endfunction

  // frame monitor and device-chain model, all sampled on the falling system clock
  logic [W-1:0] sreg [N];
  logic ch_m [N];
  logic first_b [N];
  logic daisy;
  int conv, cyc, last_edge, hpmin, hpmax, cur_falls, cur_rises, nfr, done_cnt, mosi_bad;
  logic [W-1:0] cur_word;
  logic cs_p, sclk_p, mosi_p;
  int fr_falls [64];
  int fr_hpmin [64];
  int fr_hpmax [64];
  logic [W-1:0] fr_word [64];

  assign miso = sreg[N-1][W-1];

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) begin sreg[k] = '0; ch_m[k] = 1'b0; first_b[k] = 1'b0; end
      daisy = 1'b0; conv = 0; cyc = 0; nfr = 0; done_cnt = 0; mosi_bad = 0;
      cs_p = 1'b1; sclk_p = 1'b1; mosi_p = 1'b0;
      cur_falls = 0; cur_rises = 0; cur_word = '0; last_edge = 0; hpmin = 0; hpmax = 0;
    end else begin
      cyc++;
      if (done) done_cnt++;
      if (!cs_n && !cs_p && sclk == sclk_p && mosi != mosi_p) mosi_bad++;
      if (!cs_n && !cs_p && sclk && !sclk_p && mosi != mosi_p) mosi_bad++;
      if (cs_p && !cs_n) begin
        cur_falls = 0; cur_rises = 0; cur_word = '0; last_edge = cyc;
        hpmin = 1000000; hpmax = 0;
      end
      if (!cs_n && sclk != sclk_p) begin
        if (cyc - last_edge < hpmin) hpmin = cyc - last_edge;
        if (cyc - last_edge > hpmax) hpmax = cyc - last_edge;
        last_edge = cyc;
        if (!sclk) cur_falls++;
        else begin
          if (cur_rises < W) cur_word[W-1-cur_rises] = mosi;
          if (daisy) begin
            for (int k = N-1; k >= 0; k--) begin
              logic b;
              b = (k == 0) ? mosi : sreg[k-1][W-1];
              if (cur_rises == 0) first_b[k] = b;
              sreg[k] = {sreg[k][W-2:0], b};
            end
          end
          cur_rises++;
        end
      end
      if (!cs_p && cs_n) begin
        if (nfr < 64) begin
          fr_falls[nfr] = cur_falls; fr_word[nfr] = cur_word;
          fr_hpmin[nfr] = hpmin; fr_hpmax[nfr] = hpmax;
        end
        nfr++;
        if (!daisy) begin
          if (cur_falls == W) begin
            for (int k = 0; k < N; k++) sreg[k] = {2'b00, ch_m[k], dfn(k, ch_m[k], conv)};
            conv++;
          end else if (cur_falls >= 10 && cur_falls <= 12) daisy = 1'b1;
        end else if (cur_falls >= 10 && cur_falls <= 13) begin
          for (int k = 0; k < N; k++) ch_m[k] = first_b[k];
          daisy = 1'b0;
        end
      end
      if (cs_n && mosi) mosi_bad++;
      cs_p = cs_n; sclk_p = sclk; mosi_p = mosi;
    end
  end

  logic [N-1:0] exp_ch = '0;
  int runs = 0;

  task automatic t_run(input logic [N-1:0] cmd, input int div, input bit disturb, input string tag);
    int f0, d0, t;
    bit saw_busy;
    f0 = nfr; d0 = done_cnt; t = 0; saw_busy = 0;
    @(negedge clk); cmd_chan = cmd; clk_div = 8'(div); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done && t < 20000) begin
      @(negedge clk); t++;
      if (busy) saw_busy = 1;
      if (disturb && t == 40) begin start = 1'b1; cmd_chan = ~cmd; end
      if (disturb && t == 41) start = 1'b0;
    end
    chk(done, "R8", {tag, " done seen"}, int'(done), 1);
    chk(saw_busy, "R8", {tag, " busy during run"}, int'(saw_busy), 1);
    @(negedge clk);
    chk(!done, "R8", {tag, " done one cycle"}, int'(done), 0);
    chk(!busy, "R8", {tag, " busy cleared"}, int'(busy), 0);
    if (disturb) begin
      repeat (300) @(negedge clk);
      chk(done_cnt - d0 == 1, "R9", {tag, " single done"}, done_cnt - d0, 1);
    end
    chk(nfr - f0 == N + 3, "R2", {tag, " frame count"}, nfr - f0, N + 3);
    if (nfr - f0 == N + 3 && nfr <= 64) begin
      bit ok;
      ok = (fr_falls[f0] == W) && (fr_falls[f0+1] == ENTER) && (fr_falls[f0+N+2] == EXIT);
      for (int j = 0; j < N; j++) if (fr_falls[f0+2+j] != W) ok = 0;
      chk(ok, "R2", {tag, " falling-edge counts"}, fr_falls[f0+1], ENTER);
      ok = 1;
      for (int f = f0; f < f0 + N + 3; f++) if (fr_hpmin[f] != div + 1 || fr_hpmax[f] != div + 1) ok = 0;
      chk(ok, "R3", {tag, " half-period"}, fr_hpmax[f0], div + 1);
      chk(fr_word[f0] == '0 && fr_word[f0+1] == '0, "R6", {tag, " quiet mosi"}, int'(fr_word[f0+1]), 0);
      chk(fr_word[f0+2] == cw(1'b0), "R4", {tag, " throw-away word"}, int'(fr_word[f0+2]), int'(cw(1'b0)));
      for (int j = 1; j < N; j++)
        chk(fr_word[f0+2+j] == cw(cmd[N-j]), "R4 R10", {tag, " read command order"},
            int'(fr_word[f0+2+j]), int'(cw(cmd[N-j])));
      chk(fr_word[f0+N+2] == cw(cmd[0]), "R5 R10", {tag, " exit command"},
          int'(fr_word[f0+N+2]), int'(cw(cmd[0])));
    end
    for (int k = 0; k < N; k++) begin
      chk(res_chan[k] == exp_ch[k], "R7", {tag, " channel tag"}, int'(res_chan[k]), int'(exp_ch[k]));
      chk(res_data[k*DW +: DW] == dfn(k, exp_ch[k], runs), "R7", {tag, " data slot"},
          int'(res_data[k*DW +: DW]), int'(dfn(k, exp_ch[k], runs)));
    end
    chk(res_ok == '1, "R12", {tag, " format flags"}, int'(res_ok), (1 << N) - 1);
    chk(mosi_bad == 0, "R11 R6", {tag, " mosi edge discipline"}, mosi_bad, 0);
    exp_ch = cmd;
    runs++;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n && sclk, "R1", "serial lines idle", int'({cs_n, sclk}), 3);
    chk(!mosi && !busy && !done, "R1", "mosi/busy/done low", int'({mosi, busy, done}), 0);
    chk(res_chan == '0 && res_data == '0 && res_ok == '0, "R1", "results cleared", int'(res_data), 0);
  endtask

  task automatic t_mixed_a;    t_run(2'b10, 1, 1'b0, "mixA");    endtask
  task automatic t_mixed_b;    t_run(2'b01, 3, 1'b0, "mixB");    endtask
  task automatic t_fast;       t_run(2'b11, 0, 1'b0, "fast");    endtask
  task automatic t_disturbed;  t_run(2'b00, 2, 1'b1, "disturb"); endtask

  task automatic t_results_hold;
    logic [N*DW-1:0] snap;
    snap = res_data;
    repeat (50) @(negedge clk);
    chk(res_data == snap, "R8", "results hold while idle", int'(res_data), int'(snap));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mixed_a();
    t_mixed_b();
    t_fast();
    t_disturbed();
    t_results_hold();
    t_mixed_a();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule